// File: doc/BRIEF.md
# Flyby Single-Cycle DMA Engine

This block moves a programmed number of units between a peripheral and memory without ever holding the data itself. It takes the system bus through a HOLD/HLDA handshake and asserts a DMA acknowledge to the peripheral. It then overlaps an I/O strobe with a memory strobe, so the unit passes straight across the data bus in one bus cycle.

During that cycle the address bus carries the memory address. The peripheral ignores the address and decodes only the acknowledge together with its I/O strobe. The direction bit picks one of two pairings. In peripheral-to-memory mode the I/O read strobe opens the cycle and the memory write strobe is nested inside it. In memory-to-peripheral mode the memory read strobe opens the cycle and the I/O write strobe is nested inside it.

Software-side logic loads a base address, a unit count and a direction while the engine is idle. Each time the peripheral raises its request, the engine performs one flyby cycle, advances the address and lowers the remaining count. Between cycles it gives the bus back and waits until the grant has actually been withdrawn.

Top module: `flyby_dma`

## Requirements
- R1: After reset, hold, dack, all four strobes, addr and busy are 0.
- R2: A cfg_load pulse is accepted only when the engine is idle with no units remaining. It captures cfg_addr, cfg_count and cfg_dir. A cfg_load pulse that arrives while busy is 1 is ignored, and the running job's addresses continue unchanged.
- R3: hold rises only while dreq is 1 and units remain. dack rises only in the cycle after hlda has been sampled 1 with hold asserted. While dreq stays 0, hold stays 0.
- R4: With cfg_dir = 0 (peripheral to memory), a transfer runs for three cycles. The first cycle has io_rd alone. The second has io_rd and mem_wr together. The third has io_rd alone. mem_rd and io_wr stay 0 throughout.
- R5: With cfg_dir = 1 (memory to peripheral), a transfer runs for three cycles. The first cycle has mem_rd alone. The second has mem_rd and io_wr together. The third has mem_rd alone, so io_wr is released before mem_rd. io_rd and mem_wr stay 0 throughout.
- R6: dack is 1 whenever any strobe is 1, and for the whole three-cycle transfer. While dack is 1, addr shows the memory address. Outside a transfer, addr is 0.
- R7: The k-th transfer of a job (counting from 0) drives addr = base + k, modulo 2^AW. After exactly cfg_count transfers, busy falls to 0 and hold is no longer raised.
- R8: After hold is released, hold is not raised again until hlda has been sampled 0.
- R9: mem_rd and mem_wr are never 1 together, and io_rd and io_wr are never 1 together.
- R10: Loading cfg_count = 0 starts no transfer: hold, dack and busy stay 0 even while dreq is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load pulse for a new job |
| cfg_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_addr | input | AW | Base memory address |
| cfg_count | input | CW | Number of units to move |
| dreq | input | 1 | Peripheral service request |
| hlda | input | 1 | Bus grant from the current owner |
| hold | output | 1 | Bus request to the current owner |
| dack | output | 1 | Acknowledge that selects the peripheral |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| addr | output | AW | Memory address during a transfer |
| busy | output | 1 | Job in progress or units remaining |

## Verification
The hardest situation to reach is the turnaround between two transfers. In that window the engine has dropped hold and the peripheral is still requesting, but the grant has not yet fallen. A careless design would re-take the bus at that point. The bench reaches it with a bus-owner model that answers both hold edges after a random lag of 0 to 3 cycles, while dreq is kept high across whole jobs. Every rising edge of hold is then checked against the grant sampled in the cycle before.

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_dir,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          dreq,
  input  logic          hlda,
  output logic          hold,
  output logic          dack,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  output logic [AW-1:0] addr,
  output logic          busy
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_LEAD, S_BOTH, S_TAIL, S_DROP} st_t;

  st_t           st;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] remain;
  logic          dir;
  logic          left;

  assign left = (remain != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      dir      <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (cfg_load && !left) begin
            cur_addr <= cfg_addr;
            remain   <= cfg_count;
            dir      <= cfg_dir;
          end else if (left && dreq) begin
            st <= S_REQ;
          end
        end
        S_REQ:  if (hlda) st <= S_LEAD;
        S_LEAD: st <= S_BOTH;
        S_BOTH: st <= S_TAIL;
        S_TAIL: begin
          st       <= S_DROP;
          cur_addr <= cur_addr + 1'b1;
          remain   <= remain - 1'b1;
        end
        S_DROP: if (!hlda) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic trail;
  assign dack   = (st == S_LEAD) || (st == S_BOTH) || (st == S_TAIL);
  assign trail  = (st == S_BOTH);
  assign hold   = (st == S_REQ) || dack;
  assign mem_rd = dack & dir;
  assign io_rd  = dack & ~dir;
  assign io_wr  = trail & dir;
  assign mem_wr = trail & ~dir;
  assign addr   = dack ? cur_addr : '0;
  assign busy   = (st != S_IDLE) || left;

endmodule

module flyby_dma_chk (
  input logic clk,
  input logic rst_n,
  input logic hlda,
  input logic hold,
  input logic dack,
  input logic mem_rd,
  input logic mem_wr,
  input logic io_rd,
  input logic io_wr
);

  a_r9_no_strobe_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(io_rd && io_wr));

  a_r6_dack_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |-> dack);

  a_r4_wr_nested: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (io_rd && $past(io_rd)));

  a_r5_wr_nested: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> (mem_rd && $past(mem_rd)));

  a_r5_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_wr) |-> mem_rd);

  a_r3_granted_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack) |-> ($past(hold) && $past(hlda)));

  a_r8_grant_gone: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> !$past(hlda));

endmodule

bind flyby_dma flyby_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hlda(hlda), .hold(hold), .dack(dack),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
);

// File: tb/sim_flyby_dma.sv
`timescale 1ns/1ps
module sim_flyby_dma;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_dir = 1'b0, dreq = 1'b0, hlda = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic hold, dack, mem_rd, mem_wr, io_rd, io_wr, busy;
  logic [AW-1:0] addr;

  int n_chk = 0, n_fail = 0;
  int lag = 0;
  logic prev_hold = 1'b0, prev_hlda = 1'b0;

  always #5 clk = ~clk;

  flyby_dma #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_dir(cfg_dir),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .dreq(dreq), .hlda(hlda),
    .hold(hold), .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .addr(addr), .busy(busy));

  always @(posedge clk) begin
    if (!rst_n) begin
      hlda <= 1'b0;
      lag  <= 0;
    end else if (hold != hlda) begin
      if (lag == 0) begin
        hlda <= hold;
        lag  <= int'($urandom % 4);
      end else begin
        lag <= lag - 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold && !prev_hold) check("R8 hold rose with grant still seen", {31'b0, prev_hlda}, 32'd0);
      prev_hold <= hold;
      prev_hlda <= hlda;
    end
  end

  function automatic logic [3:0] pat(input logic d, input int phase);
    logic lead, trl;
    lead = (phase < 3);
    trl  = (phase == 1);
    return {lead & d, trl & ~d, lead & ~d, trl & d};
  endfunction

  task automatic load(input logic [AW-1:0] a, input logic [CW-1:0] c, input logic d);
    @(negedge clk);
    cfg_addr = a; cfg_count = c; cfg_dir = d; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic one_xfer(input logic [AW-1:0] ea, input logic d);
    int t = 0;
    while (!dack && t < 60) begin @(negedge clk); t++; end
    check("R3 dack reached", {31'b0, dack}, 32'd1);
    for (int ph = 0; ph < 4; ph++) begin
      check(d ? "R5 strobe pattern" : "R4 strobe pattern",
            {28'b0, mem_rd, mem_wr, io_rd, io_wr}, {28'b0, pat(d, ph)});
      check("R6 dack span", {31'b0, dack}, {31'b0, ph < 3});
      check("R7 address", {16'b0, addr}, (ph < 3) ? {16'b0, ea} : 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic run_job(input logic [AW-1:0] a, input int c, input logic d, input logic poke);
    load(a, CW'(c), d);
    dreq = 1'b1;
    for (int k = 0; k < c; k++) begin
      if (poke && k == 1) begin
        cfg_addr = a + 16'h0100; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
      end
      one_xfer(a + AW'(k), d);
    end
    dreq = 1'b0;
    for (int i = 0; i < 8; i++) @(negedge clk);
    check("R7 busy cleared", {31'b0, busy}, 32'd0);
    check("R7 hold idle", {31'b0, hold}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 outputs", {21'b0, hold, dack, mem_rd, mem_wr, io_rd, io_wr, busy, 4'b0}, 32'd0);
    check("R1 addr", {16'b0, addr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_job(16'h1000, 3, 1'b0, 1'b0);
    run_job(16'h2000, 3, 1'b1, 1'b0);
    run_job(16'hFFFE, 4, 1'b1, 1'b0);

    run_job(16'h3000, 4, 1'b0, 1'b1);

    load(16'h4000, 16'd0, 1'b0);
    dreq = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 0) check("R10 no activity", {30'b0, hold, busy}, 32'd0);
    end
    dreq = 1'b0;

    load(16'h5000, 16'd2, 1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i % 3 == 0) check("R3 hold waits for dreq", {31'b0, hold}, 32'd0);
    end
    check("R2 busy after load", {31'b0, busy}, 32'd1);
    dreq = 1'b1;
    one_xfer(16'h5000, 1'b1);
    one_xfer(16'h5001, 1'b1);
    dreq = 1'b0;
    repeat (8) @(negedge clk);
    check("R7 done", {31'b0, busy}, 32'd0);

    for (int j = 0; j < 12; j++) begin
      run_job(AW'($urandom), 1 + int'($urandom % 5), 1'($urandom), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule